// File: doc/BRIEF.md
# Double-Buffered DAC Parallel Write Interface

This block is the digital front end of a 12-bit voltage-output converter. A host drives a 12-bit parallel word together with an active-low chip select, an active-low write strobe and a register-select pin. Each completed write lands in one of two places. With the select pin low it goes to a data holding latch. With the select pin high it goes to a sparse control register, which decodes a settling-speed flag, a power-down flag and a reference-source choice. All host pins are asynchronous to the system clock. Each one passes through a two-flop synchronizer before it is used.

A separate active-low load strobe copies the holding latch into the DAC latch that feeds the converter. New codes can therefore be staged ahead of time and applied at a moment the host picks. While power-down is set, the code driven to the converter is zero. The DAC latch keeps its contents, so the previous code comes back when power-down is cleared. A small two-state machine tracks the synchronized write strobe. The states are WR_IDLE (strobe high) and WR_LOW (strobe low). The transitions are:
- WR_IDLE to WR_LOW when the strobe falls.
- WR_LOW to WR_IDLE when the strobe rises. This transition commits the write if chip select is low.

Top module: `dac_par_if`

## Requirements
- R1: After reset, dac_code is 0, pwr_down is 0, fast_mode is 0 and ref_mode is 2'b00 (external).
- R2: A word is stored only when wr_n rises while cs_n is low. A write strobe with cs_n high changes neither the holding latch nor the control register.
- R3: A write with sel_ctrl=0 goes to the holding latch only. A write with sel_ctrl=1 goes to the control register only.
- R4: While load_n stays high, holding-latch writes do not change dac_code. A low pulse on load_n copies the holding latch to dac_code.
- R5: While load_n is held low, a data write reaches dac_code without any further strobe.
- R6: Control bit 0 sets fast_mode: 1 selects fast settling and 0 selects slow settling.
- R7: Control bit 1 set to 1 drives pwr_down high and forces dac_code to 0. Clearing it restores the code the DAC latch held before power-down.
- R8: Control bits 4:3 select the reference. Values 00 and 11 give ref_mode 2'b00 (external), 01 gives 2'b01 (internal 1.024 V) and 10 gives 2'b10 (internal 2.048 V). ref_mode never shows 2'b11.
- R9: Control bits 11:5 and bit 2 have no effect on any output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Active-low chip select, asynchronous |
| wr_n | input | 1 | Active-low write strobe; the write commits on its rising edge |
| sel_ctrl | input | 1 | 0 selects the holding latch, 1 selects the control register |
| load_n | input | 1 | Active-low load of the DAC latch from the holding latch |
| data_in | input | 12 | Parallel write data |
| dac_code | output | 12 | Code driven to the converter (0 while powered down) |
| pwr_down | output | 1 | Power-down request |
| fast_mode | output | 1 | Fast settling selected |
| ref_mode | output | 2 | 00 external, 01 internal 1.024 V, 10 internal 2.048 V |

## Verification
A bad holding latch stays hidden until the next load pulse, and then dac_code shows the wrong value within four clocks of load_n falling. The bench therefore loads after every write it wants to inspect, including writes that should have been ignored. A corrupted control register appears on pwr_down, fast_mode or ref_mode three clocks after the write strobe rises. A DAC latch that power-down has disturbed shows up only after wake-up, as a restored code different from the one held before power-down.

// File: rtl/dacif_pkg.sv
package dacif_pkg;
    localparam int SPD_BIT = 0;
    localparam int PWR_BIT = 1;
    localparam int REF_LSB = 3;
    localparam int REF_W   = 2;

    typedef enum logic [1:0] {
        REF_EXT    = 2'b00,
        REF_INT_LO = 2'b01,
        REF_INT_HI = 2'b10
    } ref_src_e;

    typedef enum logic {
        WR_IDLE = 1'b0,
        WR_LOW  = 1'b1
    } wr_state_e;

    typedef struct packed {
        ref_src_e refsel;
        logic     pd;
        logic     fast;
    } ctrl_t;
endpackage

// File: rtl/dacif_sync.sv
module dacif_sync #(
    parameter int W = 1,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] meta;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            meta <= RST_VAL;
            q    <= RST_VAL;
        end else begin
            meta <= d;
            q    <= meta;
        end
    end
endmodule

// File: rtl/dacif_wr_fsm.sv
module dacif_wr_fsm
    import dacif_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic wr_s,
    input  logic cs_s,
    output logic strobe
);
    wr_state_e state, state_nx;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= WR_IDLE;
        else        state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        strobe   = 1'b0;
        unique case (state)
            WR_IDLE: begin
                if (!wr_s) state_nx = WR_LOW;
            end
            WR_LOW: begin
                if (wr_s) begin
                    state_nx = WR_IDLE;
                    strobe   = !cs_s;
                end
            end
        endcase
    end
endmodule

// File: rtl/dacif_regs.sv
module dacif_regs
    import dacif_pkg::*;
#(
    parameter int DATA_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              strobe,
    input  logic              sel,
    input  logic [DATA_W-1:0] data,
    output logic [DATA_W-1:0] hold_q,
    output ctrl_t             ctrl_q
);
    localparam int REF_MSB = REF_LSB + REF_W - 1;

    logic [REF_W-1:0] ref_raw;
    ctrl_t            ctrl_nx;
    logic             unused_bits;

    assign ref_raw     = data[REF_MSB:REF_LSB];
    assign unused_bits = ^{data[DATA_W-1:REF_MSB+1], data[2]};

    always_comb begin
        ctrl_nx.fast = data[SPD_BIT];
        ctrl_nx.pd   = data[PWR_BIT];
        case (ref_raw)
            2'b01:   ctrl_nx.refsel = REF_INT_LO;
            2'b10:   ctrl_nx.refsel = REF_INT_HI;
            default: ctrl_nx.refsel = REF_EXT;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hold_q <= '0;
            ctrl_q <= '{refsel: REF_EXT, pd: 1'b0, fast: 1'b0};
        end else if (strobe) begin
            if (sel) ctrl_q <= ctrl_nx;
            else     hold_q <= data;
        end
    end
endmodule

// File: rtl/dacif_dac_latch.sv
module dacif_dac_latch #(
    parameter int DATA_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_s,
    input  logic              pd,
    input  logic [DATA_W-1:0] hold,
    output logic [DATA_W-1:0] latch_q,
    output logic [DATA_W-1:0] code
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       latch_q <= '0;
        else if (!load_s) latch_q <= hold;
    end

    assign code = pd ? '0 : latch_q;
endmodule

// File: rtl/dac_par_if.sv
module dac_par_if
    import dacif_pkg::*;
#(
    parameter int DATA_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_n,
    input  logic              wr_n,
    input  logic              sel_ctrl,
    input  logic              load_n,
    input  logic [DATA_W-1:0] data_in,
    output logic [DATA_W-1:0] dac_code,
    output logic              pwr_down,
    output logic              fast_mode,
    output logic [1:0]        ref_mode
);
    localparam int BUS_W = DATA_W + 1;

    logic [2:0]        strb_s;
    logic [BUS_W-1:0]  bus_s;
    logic              wr_s, cs_s, load_s, sel_s;
    logic [DATA_W-1:0] data_s;
    logic              wr_strobe;
    logic [DATA_W-1:0] hold_q, latch_q;
    ctrl_t             ctrl_q;

    dacif_sync #(.W(3), .RST_VAL(3'b111)) u_sync_strb (
        .clk(clk), .rst_n(rst_n), .d({wr_n, cs_n, load_n}), .q(strb_s)
    );

    dacif_sync #(.W(BUS_W), .RST_VAL('0)) u_sync_bus (
        .clk(clk), .rst_n(rst_n), .d({sel_ctrl, data_in}), .q(bus_s)
    );

    assign {wr_s, cs_s, load_s} = strb_s;
    assign {sel_s, data_s}      = bus_s;

    dacif_wr_fsm u_fsm (
        .clk(clk), .rst_n(rst_n), .wr_s(wr_s), .cs_s(cs_s), .strobe(wr_strobe)
    );

    dacif_regs #(.DATA_W(DATA_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .strobe(wr_strobe), .sel(sel_s),
        .data(data_s), .hold_q(hold_q), .ctrl_q(ctrl_q)
    );

    dacif_dac_latch #(.DATA_W(DATA_W)) u_latch (
        .clk(clk), .rst_n(rst_n), .load_s(load_s), .pd(ctrl_q.pd),
        .hold(hold_q), .latch_q(latch_q), .code(dac_code)
    );

    assign pwr_down  = ctrl_q.pd;
    assign fast_mode = ctrl_q.fast;
    assign ref_mode  = ctrl_q.refsel;
endmodule

// File: rtl/dac_par_if_chk.sv
module dac_par_if_chk
    import dacif_pkg::*;
#(
    parameter int DATA_W = 12
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_strobe,
    input logic              sel_s,
    input logic              load_s,
    input logic [DATA_W-1:0] hold_q,
    input logic [DATA_W-1:0] latch_q,
    input ctrl_t             ctrl_q,
    input logic [DATA_W-1:0] dac_code,
    input logic              pwr_down,
    input logic [1:0]        ref_mode
);
    a_r2_no_store_without_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_strobe |=> ($stable(hold_q) && $stable(ctrl_q)));

    a_r3_ctrl_write_spares_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_strobe && sel_s) |=> $stable(hold_q));

    a_r3_data_write_spares_ctrl: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_strobe && !sel_s) |=> $stable(ctrl_q));

    a_r4_latch_holds_without_load: assert property (@(posedge clk) disable iff (!rst_n)
        load_s |=> $stable(latch_q));

    a_r5_load_copies_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !load_s |=> (latch_q == $past(hold_q)));

    a_r7_pd_zero_code: assert property (@(posedge clk) disable iff (!rst_n)
        pwr_down |-> (dac_code == '0));

    a_r8_ref_legal: assert property (@(posedge clk) disable iff (!rst_n)
        ref_mode != 2'b11);
endmodule

bind dac_par_if dac_par_if_chk #(.DATA_W(DATA_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .wr_strobe(wr_strobe), .sel_s(sel_s),
    .load_s(load_s), .hold_q(hold_q), .latch_q(latch_q), .ctrl_q(ctrl_q),
    .dac_code(dac_code), .pwr_down(pwr_down), .ref_mode(ref_mode)
);

// File: tb/tb_dac_par_if.sv
`timescale 1ns/1ps
module tb_dac_par_if;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cs_n = 1'b1;
    logic        wr_n = 1'b1;
    logic        sel_ctrl = 1'b0;
    logic        load_n = 1'b1;
    logic [11:0] data_in = '0;
    logic [11:0] dac_code;
    logic        pwr_down, fast_mode;
    logic [1:0]  ref_mode;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    dac_par_if dut (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .wr_n(wr_n), .sel_ctrl(sel_ctrl),
        .load_n(load_n), .data_in(data_in), .dac_code(dac_code),
        .pwr_down(pwr_down), .fast_mode(fast_mode), .ref_mode(ref_mode)
    );

    task automatic check(input string req, input int got, input int exp);
        checks++;
        if (got != exp) begin
            errors++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, got, exp);
        end
    endtask

    task automatic cycles(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic write_word(input logic to_ctrl, input logic [11:0] w, input logic select);
        data_in  = w;
        sel_ctrl = to_ctrl;
        cs_n     = !select;
        cycles(2);
        wr_n = 1'b0;
        cycles(3);
        wr_n = 1'b1;
        cycles(5);
        cs_n = 1'b1;
        cycles(3);
    endtask

    task automatic pulse_load();
        load_n = 1'b0;
        cycles(3);
        load_n = 1'b1;
        cycles(5);
    endtask

    task automatic t_reset();
        check("R1 dac_code", dac_code, 0);
        check("R1 pwr_down", pwr_down, 0);
        check("R1 fast_mode", fast_mode, 0);
        check("R1 ref_mode", ref_mode, 0);
    endtask

    task automatic t_double_buffer();
        write_word(1'b0, 12'hA5C, 1'b1);
        check("R4 staged not applied", dac_code, 0);
        pulse_load();
        check("R4 load applies", dac_code, 12'hA5C);
    endtask

    task automatic t_chip_select();
        write_word(1'b0, 12'h123, 1'b0);
        pulse_load();
        check("R2 data write without cs", dac_code, 12'hA5C);
        write_word(1'b1, 12'h001, 1'b0);
        check("R2 ctrl write without cs", fast_mode, 0);
    endtask

    task automatic t_select();
        write_word(1'b1, 12'h001, 1'b1);
        check("R6 fast set", fast_mode, 1);
        pulse_load();
        check("R3 ctrl write leaves hold", dac_code, 12'hA5C);
        write_word(1'b0, 12'h3FF, 1'b1);
        check("R3 data write leaves ctrl", fast_mode, 1);
        check("R4 still staged", dac_code, 12'hA5C);
        write_word(1'b1, 12'h000, 1'b1);
        check("R6 slow set", fast_mode, 0);
    endtask

    task automatic t_reference();
        int exp_tab[4] = '{0, 1, 2, 0};
        for (int v = 0; v < 4; v++) begin
            write_word(1'b1, 12'(v << 3), 1'b1);
            check("R8 ref decode", ref_mode, exp_tab[v]);
        end
    endtask

    task automatic t_ignored();
        write_word(1'b1, 12'hFE4, 1'b1);
        check("R9 pwr_down", pwr_down, 0);
        check("R9 fast_mode", fast_mode, 0);
        check("R9 ref_mode", ref_mode, 0);
        check("R9 dac_code", dac_code, 12'hA5C);
    endtask

    task automatic t_power();
        pulse_load();
        check("R4 second load", dac_code, 12'h3FF);
        write_word(1'b1, 12'h002, 1'b1);
        check("R7 pwr_down high", pwr_down, 1);
        check("R7 code forced zero", dac_code, 0);
        write_word(1'b1, 12'h000, 1'b1);
        check("R7 pwr_down low", pwr_down, 0);
        check("R7 code restored", dac_code, 12'h3FF);
    endtask

    task automatic t_transparent();
        load_n = 1'b0;
        cycles(4);
        write_word(1'b0, 12'h7E1, 1'b1);
        check("R5 transparent first", dac_code, 12'h7E1);
        write_word(1'b0, 12'h0F0, 1'b1);
        check("R5 transparent second", dac_code, 12'h0F0);
        load_n = 1'b1;
        cycles(4);
        write_word(1'b0, 12'h555, 1'b1);
        check("R4 hold after release", dac_code, 12'h0F0);
    endtask

    initial begin
        cycles(3);
        rst_n = 1'b1;
        cycles(3);
        t_reset();
        t_double_buffer();
        t_chip_select();
        t_select();
        t_reference();
        t_ignored();
        t_power();
        t_transparent();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule